// File: doc/BRIEF.md
# I3C Command Descriptor Decoder with Receipts

This block sits between a command stream and the bus framer of an I3C controller. Software pushes descriptors of two 32-bit words each. The block decodes each descriptor into a transfer request: either a common command code (CCC) or a private transfer. It hands the request to the framer with a one-cycle start pulse, together with a stable set of fields. It also tells the framer how to end the transfer. The ending is a stop, a repeated start, or a direct continuation when the following descriptor is already waiting.

When the framer reports completion, the block builds a 32-bit receipt from the outcome. The framer reports broadcast-address NACK, peripheral NACK, a malformed CCC, a monitoring error and the count of bytes received. The receipt holds an error code, the length actually moved and a wrapping 8-bit sync tag. It is queued on a receipt stream and an interrupt request pulses. A NACK never stalls the block; it reports the outcome and moves on to the next descriptor. The receipt queue is never allowed to overflow, because a command starts only when a slot is free for its receipt.

Top module: `i3c_cmd_decoder`

## Requirements
- R1: In the first descriptor word, the fields are: bit 30 = CCC select, bit 29 = broadcast header, bit 25 = repeated start wanted, bits 23:12 = length, bits 7:1 = device address, bit 0 = read. They appear on the `req_*` outputs in the cycle where `req_start` is high for one cycle, and they stay stable until the next start.
- R2: For a CCC, bit 7 of the second word sets `req_ccc_direct` and bits 6:0 set `req_ccc_code`. `req_bcast` is 1 whatever bit 29 holds. For a private transfer, `req_ccc_direct` and `req_ccc_code` are 0.
- R3: The following bits have no effect on the request: bits 31, 28:27, 26, 24 and 11:8 of the first word, and the whole second word of a private transfer.
- R4: `req_end` is 0 (stop) or 1 (repeated start), following bit 25. It is 2 (continue) when a complete next descriptor is held and the receipt queue has room for two more entries. In that case `req_start` for the next descriptor rises in the cycle after `fr_done`.
- R5: One receipt is queued per `fr_done` of an executing command. Its layout is: error code in bits 27:24, length in bits 19:8, sync tag in bits 7:0, and zeros elsewhere. `irq` is high for one cycle, in the first cycle the receipt is visible.
- R6: The sync tag is 0 for the first command after reset. It rises by one per command and wraps from 255 to 0.
- R7: The reported length depends on the direction. For a read it equals `fr_count`. For a write it is 0 after either NACK, and the requested length otherwise.
- R8: The error code is chosen in this order of priority: 3 for a broadcast NACK, then 9 for a peripheral NACK, then 1 for a malformed CCC (counted only for CCCs), then 2 for a monitoring error, and 0 otherwise.
- R9: A command word is taken when `cmd_valid` and `cmd_ready` are both high. Only a descriptor whose two words have both arrived can start. `cmd_ready` is low while such a descriptor waits.
- R10: The receipt queue holds RCPT_DEPTH entries. While it is full, no new command starts. One pop lets the waiting command start.
- R11: After a command that ends in a NACK, the next descriptor is started normally.
- R12: After reset: `cmd_ready`=1, `rcpt_valid`=0, `req_start`=0, `irq`=0 and `req_end`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted when high with valid |
| cmd_data | input | 32 | Command word (first, then second word of a descriptor) |
| req_start | output | 1 | One-cycle pulse starting a transfer in the framer |
| req_ccc | output | 1 | Transfer is a CCC |
| req_ccc_direct | output | 1 | CCC is direct (1) or broadcast (0) |
| req_ccc_code | output | 7 | CCC code byte |
| req_bcast | output | 1 | Send the broadcast header first |
| req_addr | output | 7 | Target device address |
| req_rnw | output | 1 | Read (1) or write (0) |
| req_len | output | 12 | Requested payload length in bytes |
| req_end | output | 2 | Ending: 0 stop, 1 repeated start, 2 continue |
| fr_done | input | 1 | Framer finished the current transfer |
| fr_bcast_nack | input | 1 | Broadcast address was not acknowledged |
| fr_addr_nack | input | 1 | Peripheral did not acknowledge |
| fr_ccc_bad | input | 1 | Unexpected byte count in a CCC |
| fr_monitor_err | input | 1 | Bus monitoring error |
| fr_count | input | 12 | Bytes received in a read |
| rcpt_valid | output | 1 | A receipt is available |
| rcpt_ready | input | 1 | Receipt consumer takes the head entry |
| rcpt_data | output | 32 | Head receipt word |
| irq | output | 1 | One-cycle pulse per queued receipt |

## Verification
The assertions assume that the framer raises `fr_done` only while a command it was given is outstanding, and exactly once per `req_start`. They also assume the command stream presents the words of a descriptor in order. The bench framer model keeps to this rule. It waits for each start pulse and then drives a single completion pulse, with the outcome flags valid only in that cycle. It never pulses completion while idle. Inputs change only on falling edges, so every handshake is decided at a clean rising edge.

// File: rtl/i3cd_pkg.sv
package i3cd_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 12;
  localparam int ADDR_W = 7;
  localparam int CODE_W = 7;
  localparam int SYNC_W = 8;
  localparam int ERR_W  = 4;

  // first-word field positions (decoded by software, so kept fixed)
  localparam int F_CCC     = 30;
  localparam int F_BCAST   = 29;
  localparam int F_SR      = 25;
  localparam int F_LEN_LO  = 12;
  localparam int F_ADDR_LO = 1;
  localparam int F_RNW     = 0;
  localparam int F_DIRECT  = 7;

  // receipt field positions
  localparam int R_ERR_LO = 24;
  localparam int R_LEN_LO = 8;

  localparam logic [1:0] END_STOP   = 2'd0;
  localparam logic [1:0] END_RSTART = 2'd1;
  localparam logic [1:0] END_CHAIN  = 2'd2;

  localparam logic [ERR_W-1:0] ERR_NONE  = 4'd0;
  localparam logic [ERR_W-1:0] ERR_CCC   = 4'd1;
  localparam logic [ERR_W-1:0] ERR_MON   = 4'd2;
  localparam logic [ERR_W-1:0] ERR_BCAST = 4'd3;
  localparam logic [ERR_W-1:0] ERR_NACK  = 4'd9;

  typedef enum logic {SQ_IDLE, SQ_BUSY} sq_state_e;

  typedef struct packed {
    logic              is_ccc;
    logic              bcast;
    logic              sr;
    logic              rnw;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              direct;
    logic [CODE_W-1:0] code;
  } desc_t;

  function automatic desc_t decode_desc(input logic [WORD_W-1:0] w0,
                                        input logic [WORD_W-1:0] w1);
    desc_t d;
    d.is_ccc = w0[F_CCC];
    d.bcast  = w0[F_CCC] | w0[F_BCAST];
    d.sr     = w0[F_SR];
    d.rnw    = w0[F_RNW];
    d.addr   = w0[F_ADDR_LO +: ADDR_W];
    d.len    = w0[F_LEN_LO +: LEN_W];
    d.direct = w0[F_CCC] & w1[F_DIRECT];
    d.code   = w0[F_CCC] ? w1[CODE_W-1:0] : '0;
    return d;
  endfunction

  function automatic logic [ERR_W-1:0] classify(input logic is_ccc,
                                                input logic bcast_nack,
                                                input logic addr_nack,
                                                input logic ccc_bad,
                                                input logic mon_err);
    if (bcast_nack)            return ERR_BCAST;
    else if (addr_nack)        return ERR_NACK;
    else if (is_ccc && ccc_bad) return ERR_CCC;
    else if (mon_err)          return ERR_MON;
    return ERR_NONE;
  endfunction

  function automatic logic [WORD_W-1:0] pack_rcpt(input logic [ERR_W-1:0]  err,
                                                  input logic [LEN_W-1:0]  len,
                                                  input logic [SYNC_W-1:0] sync);
    logic [WORD_W-1:0] r;
    r = '0;
    r[R_ERR_LO +: ERR_W] = err;
    r[R_LEN_LO +: LEN_W] = len;
    r[0 +: SYNC_W]       = sync;
    return r;
  endfunction

endpackage

// File: rtl/i3cd_cmd_collect.sv
module i3cd_cmd_collect #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [WORD_W-1:0]         cmd_data,
  input  logic                      take,
  output logic                      full,
  output logic [N_WORDS*WORD_W-1:0] words
);

  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [IDX_W-1:0]  idx_q;
  logic              full_q;
  logic [WORD_W-1:0] slot_q [N_WORDS];
  logic              accept;

  assign accept    = cmd_valid && !full_q;
  assign cmd_ready = !full_q;
  assign full      = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (take) full_q <= 1'b0;
      if (accept) begin
        if (idx_q == LAST_IDX) begin
          idx_q  <= '0;
          full_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[g] <= '0;
      else if (accept && idx_q == IDX_W'(g)) slot_q[g] <= cmd_data;
    end
    assign words[g*WORD_W +: WORD_W] = slot_q[g];
  end

  AST_TAKE_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    take |-> full_q); // R9

endmodule

// File: rtl/i3cd_rcpt_fifo.sv
module i3cd_rcpt_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign pop      = rd_ready && (cnt_q != '0);
  assign rd_valid = (cnt_q != '0);
  assign rd_data  = mem[rd_ptr];
  assign count    = cnt_q;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_RCPT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < DEPTH_C)); // R10

endmodule

// File: rtl/i3cd_sequencer.sv
module i3cd_sequencer import i3cd_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pend_full,
  input  logic [2*WORD_W-1:0]  words,
  input  logic [CNT_W-1:0]     rcpt_count,
  input  logic                 fr_done,
  input  logic                 fr_bcast_nack,
  input  logic                 fr_addr_nack,
  input  logic                 fr_ccc_bad,
  input  logic                 fr_monitor_err,
  input  logic [LEN_W-1:0]     fr_count,
  output logic                 take,
  output logic                 push,
  output logic [WORD_W-1:0]    push_data,
  output logic                 req_start,
  output desc_t                cur,
  output logic [1:0]           req_end,
  output logic                 irq
);

  localparam logic [CNT_W-1:0] ROOM_ONE = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ROOM_TWO = CNT_W'(DEPTH - 1);

  sq_state_e         state_q;
  desc_t             dec;
  logic [SYNC_W-1:0] sync_q;
  logic [1:0]        end_q;
  logic              start_q, irq_q;
  logic              issue_idle, issue_chain;
  logic              nack_any;
  logic [ERR_W-1:0]  err;
  logic [LEN_W-1:0]  len_rep;

  assign dec = decode_desc(words[WORD_W-1:0], words[2*WORD_W-1:WORD_W]);

  assign issue_idle  = (state_q == SQ_IDLE) && pend_full && (rcpt_count < ROOM_ONE);
  assign issue_chain = (state_q == SQ_BUSY) && fr_done && (end_q == END_CHAIN);
  assign take        = issue_idle || issue_chain;
  assign push        = (state_q == SQ_BUSY) && fr_done;

  assign nack_any  = fr_bcast_nack | fr_addr_nack;
  assign err       = classify(cur.is_ccc, fr_bcast_nack, fr_addr_nack, fr_ccc_bad, fr_monitor_err);
  assign len_rep   = cur.rnw ? fr_count : (nack_any ? '0 : cur.len);
  assign push_data = pack_rcpt(err, len_rep, sync_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cur     <= '0;
      sync_q  <= '0;
      end_q   <= END_STOP;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      irq_q   <= push;
      if (push) sync_q <= sync_q + 1'b1;
      if (take) begin
        cur     <= dec;
        start_q <= 1'b1;
        end_q   <= dec.sr ? END_RSTART : END_STOP;
        state_q <= SQ_BUSY;
      end else if (push) begin
        state_q <= SQ_IDLE;
        end_q   <= END_STOP;
      end else if (state_q == SQ_BUSY) begin
        end_q <= (pend_full && rcpt_count < ROOM_TWO) ? END_CHAIN
               : (cur.sr ? END_RSTART : END_STOP);
      end else begin
        end_q <= END_STOP;
      end
    end
  end

  assign req_start = start_q;
  assign req_end   = end_q;
  assign irq       = irq_q;

  AST_START_NEEDS_DESC: assert property (@(posedge clk) disable iff (rst)
    req_start |-> $past(pend_full)); // R9

endmodule

// File: rtl/i3c_cmd_decoder.sv
module i3c_cmd_decoder import i3cd_pkg::*; #(
  parameter int RCPT_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_data,
  output logic        req_start,
  output logic        req_ccc,
  output logic        req_ccc_direct,
  output logic [6:0]  req_ccc_code,
  output logic        req_bcast,
  output logic [6:0]  req_addr,
  output logic        req_rnw,
  output logic [11:0] req_len,
  output logic [1:0]  req_end,
  input  logic        fr_done,
  input  logic        fr_bcast_nack,
  input  logic        fr_addr_nack,
  input  logic        fr_ccc_bad,
  input  logic        fr_monitor_err,
  input  logic [11:0] fr_count,
  output logic        rcpt_valid,
  input  logic        rcpt_ready,
  output logic [31:0] rcpt_data,
  output logic        irq
);

  localparam int CNT_W = $clog2(RCPT_DEPTH + 1);

  logic                pend_full, take, push;
  logic [2*WORD_W-1:0] words;
  logic [CNT_W-1:0]    rcpt_count;
  logic [WORD_W-1:0]   push_data;
  desc_t               cur;

  i3cd_cmd_collect #(.WORD_W(WORD_W), .N_WORDS(2)) u_collect (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .take(take), .full(pend_full), .words(words)
  );

  i3cd_sequencer #(.DEPTH(RCPT_DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst),
    .pend_full(pend_full), .words(words), .rcpt_count(rcpt_count),
    .fr_done(fr_done), .fr_bcast_nack(fr_bcast_nack), .fr_addr_nack(fr_addr_nack),
    .fr_ccc_bad(fr_ccc_bad), .fr_monitor_err(fr_monitor_err), .fr_count(fr_count),
    .take(take), .push(push), .push_data(push_data),
    .req_start(req_start), .cur(cur), .req_end(req_end), .irq(irq)
  );

  i3cd_rcpt_fifo #(.WIDTH(WORD_W), .DEPTH(RCPT_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(push_data),
    .rd_valid(rcpt_valid), .rd_ready(rcpt_ready), .rd_data(rcpt_data),
    .count(rcpt_count)
  );

  assign req_ccc        = cur.is_ccc;
  assign req_ccc_direct = cur.direct;
  assign req_ccc_code   = cur.code;
  assign req_bcast      = cur.bcast;
  assign req_addr       = cur.addr;
  assign req_rnw        = cur.rnw;
  assign req_len        = cur.len;

  AST_CHAIN_NEEDS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_end == END_CHAIN) |-> pend_full); // R4

  AST_IRQ_WITH_RCPT: assert property (@(posedge clk) disable iff (rst)
    irq |-> rcpt_valid); // R5

  AST_CCC_HAS_BCAST: assert property (@(posedge clk) disable iff (rst)
    req_ccc |-> req_bcast); // R2

endmodule

// File: tb/i3c_cmd_decoder_tb.sv
`timescale 1ns/1ps
module i3c_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic        req_start, req_ccc, req_ccc_direct, req_bcast, req_rnw;
  logic [6:0]  req_ccc_code, req_addr;
  logic [11:0] req_len;
  logic [1:0]  req_end;
  logic        fr_done = 1'b0, fr_bcast_nack = 1'b0, fr_addr_nack = 1'b0;
  logic        fr_ccc_bad = 1'b0, fr_monitor_err = 1'b0;
  logic [11:0] fr_count = '0;
  logic        rcpt_valid, rcpt_ready = 1'b0, irq;
  logic [31:0] rcpt_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_sync = '0;
  logic start_at_done = 1'b0;

  always #4 clk = ~clk;

  i3c_cmd_decoder #(.RCPT_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .req_start(req_start), .req_ccc(req_ccc), .req_ccc_direct(req_ccc_direct),
    .req_ccc_code(req_ccc_code), .req_bcast(req_bcast), .req_addr(req_addr),
    .req_rnw(req_rnw), .req_len(req_len), .req_end(req_end),
    .fr_done(fr_done), .fr_bcast_nack(fr_bcast_nack), .fr_addr_nack(fr_addr_nack),
    .fr_ccc_bad(fr_ccc_bad), .fr_monitor_err(fr_monitor_err), .fr_count(fr_count),
    .rcpt_valid(rcpt_valid), .rcpt_ready(rcpt_ready), .rcpt_data(rcpt_data), .irq(irq)
  );

  function automatic logic [31:0] mk0(input logic ccc, input logic bc, input logic sr,
                                      input logic [11:0] len, input logic [6:0] addr,
                                      input logic rnw);
    return {1'b0, ccc, bc, 2'b11, 1'b0, sr, 1'b0, len, 4'h0, addr, rnw};
  endfunction

  function automatic logic [31:0] rcpt(input logic [3:0] err, input logic [11:0] len,
                                       input logic [7:0] sync);
    return {4'h0, err, 4'h0, len, sync};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_desc(input logic [31:0] w0, input logic [31:0] w1);
    send_word(w0);
    send_word(w1);
  endtask

  task automatic wait_start(input string tag);
    int n = 0;
    while (!req_start && n < 64) begin
      @(negedge clk);
      n++;
    end
    check(tag, {31'b0, req_start}, 32'd1);
  endtask

  task automatic check_req(input string tag, input logic ccc, input logic bc,
                           input logic dir, input logic [6:0] code, input logic [6:0] addr,
                           input logic rnw, input logic [11:0] len);
    check(tag, {req_ccc, req_bcast, req_ccc_direct, req_ccc_code, req_addr, req_rnw, req_len},
          {ccc, bc, dir, code, addr, rnw, len});
  endtask

  task automatic finish_cmd(input string tag, input logic bn, input logic an, input logic cb,
                            input logic me, input logic [11:0] cnt, input logic [3:0] err,
                            input logic [11:0] len, input logic pop);
    @(negedge clk);
    fr_done = 1'b1; fr_bcast_nack = bn; fr_addr_nack = an;
    fr_ccc_bad = cb; fr_monitor_err = me; fr_count = cnt;
    @(negedge clk);
    fr_done = 1'b0; fr_bcast_nack = 1'b0; fr_addr_nack = 1'b0;
    fr_ccc_bad = 1'b0; fr_monitor_err = 1'b0; fr_count = '0;
    start_at_done = req_start;
    check({tag, " R5 irq"}, {31'b0, irq}, 32'd1);
    if (pop) begin
      check(tag, rcpt_data, rcpt(err, len, exp_sync));
      rcpt_ready = 1'b1;
      @(negedge clk);
      rcpt_ready = 1'b0;
      check({tag, " R5 irq single cycle"}, {31'b0, irq}, 32'd0);
    end
    exp_sync++;
  endtask

  task automatic pop_check(input string tag, input logic [31:0] exp);
    check({tag, " valid"}, {31'b0, rcpt_valid}, 32'd1);
    check(tag, rcpt_data, exp);
    rcpt_ready = 1'b1;
    @(negedge clk);
    rcpt_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R12 reset cmd_ready", {31'b0, cmd_ready}, 32'd1);
    check("R12 reset rcpt_valid", {31'b0, rcpt_valid}, 32'd0);
    check("R12 reset req_start", {31'b0, req_start}, 32'd0);
    check("R12 reset irq", {31'b0, irq}, 32'd0);
    check("R12 reset req_end", {30'b0, req_end}, 32'd0);
  endtask

  task automatic t_priv_write;
    send_desc(mk0(1'b0, 1'b1, 1'b0, 12'd3, 7'h2A, 1'b0), 32'h0);
    wait_start("R1 private write start");
    check_req("R1 private write fields", 1'b0, 1'b1, 1'b0, 7'h0, 7'h2A, 1'b0, 12'd3);
    check("R4 stop end", {30'b0, req_end}, 32'd0);
    finish_cmd("R5 R6 R7 write receipt", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd3, 1'b1);
    check("R5 queue drained", {31'b0, rcpt_valid}, 32'd0);
  endtask

  task automatic t_priv_read;
    send_desc(mk0(1'b0, 1'b0, 1'b0, 12'd5, 7'h11, 1'b1), 32'h0);
    wait_start("R1 private read start");
    check_req("R1 private read fields", 1'b0, 1'b0, 1'b0, 7'h0, 7'h11, 1'b1, 12'd5);
    finish_cmd("R7 short read length", 1'b0, 1'b0, 1'b0, 1'b0, 12'd2, 4'd0, 12'd2, 1'b1);
  endtask

  task automatic t_ccc;
    send_desc(mk0(1'b1, 1'b0, 1'b0, 12'd1, 7'h33, 1'b0), 32'h0000_009A);
    wait_start("R2 direct ccc start");
    check_req("R2 direct ccc fields", 1'b1, 1'b1, 1'b1, 7'h1A, 7'h33, 1'b0, 12'd1);
    finish_cmd("R2 ccc receipt", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd1, 1'b1);
    send_desc(mk0(1'b1, 1'b1, 1'b0, 12'd0, 7'h00, 1'b0), 32'h0000_0006);
    wait_start("R2 broadcast ccc start");
    check_req("R2 broadcast ccc fields", 1'b1, 1'b1, 1'b0, 7'h06, 7'h00, 1'b0, 12'd0);
    finish_cmd("R2 broadcast ccc receipt", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd0, 1'b1);
  endtask

  task automatic t_errors;
    send_desc(mk0(1'b0, 1'b0, 1'b0, 12'd4, 7'h21, 1'b0), 32'h0);
    wait_start("R8 nack start");
    finish_cmd("R7 R8 peripheral nack", 1'b0, 1'b1, 1'b0, 1'b0, 12'd0, 4'd9, 12'd0, 1'b1);
    send_desc(mk0(1'b0, 1'b1, 1'b0, 12'd4, 7'h22, 1'b1), 32'h0);
    wait_start("R11 next after nack starts");
    finish_cmd("R8 broadcast nack", 1'b1, 1'b0, 1'b0, 1'b0, 12'd0, 4'd3, 12'd0, 1'b1);
    send_desc(mk0(1'b0, 1'b1, 1'b0, 12'd4, 7'h22, 1'b0), 32'h0);
    wait_start("R8 priority start");
    finish_cmd("R8 both nacks give 3", 1'b1, 1'b1, 1'b0, 1'b1, 12'd0, 4'd3, 12'd0, 1'b1);
    send_desc(mk0(1'b1, 1'b0, 1'b0, 12'd2, 7'h40, 1'b1), 32'h0000_008D);
    wait_start("R8 ccc bad start");
    finish_cmd("R8 malformed ccc", 1'b0, 1'b0, 1'b1, 1'b1, 12'd3, 4'd1, 12'd3, 1'b1);
    send_desc(mk0(1'b0, 1'b0, 1'b0, 12'd2, 7'h41, 1'b0), 32'h0);
    wait_start("R8 private ccc flag start");
    finish_cmd("R8 ccc flag ignored for private", 1'b0, 1'b0, 1'b1, 1'b0, 12'd0, 4'd0, 12'd2, 1'b1);
    send_desc(mk0(1'b0, 1'b0, 1'b0, 12'd7, 7'h42, 1'b0), 32'h0);
    wait_start("R8 monitor start");
    finish_cmd("R8 monitor error", 1'b0, 1'b0, 1'b0, 1'b1, 12'd0, 4'd2, 12'd7, 1'b1);
  endtask

  task automatic t_ignored_bits;
    logic [31:0] w;
    w = mk0(1'b0, 1'b0, 1'b0, 12'd9, 7'h5C, 1'b1);
    w = (w & ~32'h1800_0000) | 32'h8500_0F00;
    send_desc(w, 32'hFFFF_FFFF);
    wait_start("R3 odd bits start");
    check_req("R3 odd bits have no effect", 1'b0, 1'b0, 1'b0, 7'h0, 7'h5C, 1'b1, 12'd9);
    check("R3 odd bits end mode", {30'b0, req_end}, 32'd0);
    finish_cmd("R3 odd bits receipt", 1'b0, 1'b0, 1'b0, 1'b0, 12'd9, 4'd0, 12'd9, 1'b1);
  endtask

  task automatic t_chain;
    send_desc(mk0(1'b0, 1'b0, 1'b1, 12'd2, 7'h0A, 1'b0), 32'h0);
    wait_start("R4 first start");
    check("R4 repeated start end", {30'b0, req_end}, 32'd1);
    send_desc(mk0(1'b0, 1'b1, 1'b0, 12'd6, 7'h0B, 1'b0), 32'h0);
    check("R9 ready low while descriptor waits", {31'b0, cmd_ready}, 32'd0);
    @(negedge clk);
    check("R4 continue end", {30'b0, req_end}, 32'd2);
    finish_cmd("R4 first receipt", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd2, 1'b1);
    check("R4 next start right after done", {31'b0, start_at_done}, 32'd1);
    check_req("R4 chained fields", 1'b0, 1'b1, 1'b0, 7'h0, 7'h0B, 1'b0, 12'd6);
    check("R4 chained ends with stop", {30'b0, req_end}, 32'd0);
    finish_cmd("R4 second receipt", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd6, 1'b1);
  endtask

  task automatic t_stall;
    logic [7:0] base;
    bit seen;
    base = exp_sync;
    for (int i = 0; i < 4; i++) begin
      send_desc(mk0(1'b0, 1'b0, 1'b0, 12'(i + 1), 7'h60, 1'b0), 32'h0);
      wait_start("R10 fill start");
      finish_cmd("R10 fill", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd0, 1'b0);
    end
    send_desc(mk0(1'b0, 1'b0, 1'b0, 12'd5, 7'h61, 1'b0), 32'h0);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (req_start) seen = 1'b1;
    end
    check("R10 no start while queue full", {31'b0, seen}, 32'd0);
    pop_check("R10 oldest receipt", rcpt(4'd0, 12'd1, base));
    wait_start("R10 start after one pop");
    check_req("R10 waiting fields", 1'b0, 1'b0, 1'b0, 7'h0, 7'h61, 1'b0, 12'd5);
    finish_cmd("R10 last", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd0, 1'b0);
    for (int i = 1; i < 5; i++)
      pop_check("R10 R6 drain order", rcpt(4'd0, 12'(i + 1), base + 8'(i)));
    check("R10 queue empty", {31'b0, rcpt_valid}, 32'd0);
  endtask

  task automatic t_sync_wrap;
    int n;
    n = 256 - int'(exp_sync) + 2;
    for (int i = 0; i < n; i++) begin
      send_desc(mk0(1'b0, 1'b0, 1'b0, 12'd1, 7'h70, 1'b0), 32'h0);
      wait_start("R6 wrap start");
      finish_cmd("R6 sync wrap", 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 4'd0, 12'd1, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_priv_write();
    t_priv_read();
    t_ccc();
    t_errors();
    t_ignored_bits();
    t_chain();
    t_stall();
    t_sync_wrap();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule